// File: doc/BRIEF.md
# Serial Port Register Front End with Banked Divisor

This block is the byte-wide, memory-mapped register front end of a classic asynchronous serial port. It sits on a simple synchronous bus with a 3-bit address, separate read and write strobes and combinational read data. Software uses it to program the frame format, the interrupt enable and the FIFO control, and to set a 16-bit baud divisor. It uses it again to hand transmit bytes to a serialiser, to collect received bytes, and to poll line status.

The two lowest addresses are banked. A bank-select bit in the frame-format register switches them between the data and interrupt-enable registers and the two bytes of the divisor. The divisor drives a free-running tick generator. Each tick is one sixteenth of a bit time, so the divisor is ceil(f_clk / (16 x baud)); for example, 592 gives 2400 baud from 22.729 MHz. A received byte arrives with a one-cycle valid strobe, and a single-byte holding stage connects the transmit side to the serialiser. An interrupt output is raised while received data waits and its enable is set.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, offsets 1, 2 and 3 read 0x00 and line status (offset 5) reads 0x20. The divisor reads 0x0001 (low byte 0x01, high byte 0x00). irq and tx_valid are low.
- R2: The frame-format register at offset 3 reads back all 8 written bits. Its bits 1:0 appear on word_len, where 2'b11 means 8-bit words, and its bit 7 is the bank-select bit.
- R3: With bank-select at 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Writes there leave the transmit holding register and the interrupt enable unchanged. A read of offset 0 does not consume received data.
- R4: With bank-select at 0, a write to offset 0 loads the transmit holding register, which appears on tx_data with tx_valid high. A read of offset 0 returns the last received byte, and offset 1 is the interrupt enable register.
- R5: The FIFO control register at offset 2 reads back as written, and its bit 0 appears on fifo_en.
- R6: Line status bit 0 (data ready) goes to 1 in the cycle after rx_valid. A read of offset 0 with bank-select at 0 clears it.
- R7: A byte arriving while data ready is 1, and not consumed in the same cycle, overwrites the receive buffer and sets line status bit 1 (overrun). A read of line status clears that bit.
- R8: Line status bit 5 is 1 when the transmit holding register is empty. A write of offset 0 with bank-select at 0 clears it. tx_valid is its inverse, and a cycle with tx_accept high while tx_valid is high sets it again.
- R9: irq is high exactly while interrupt-enable bit 0 and data ready are both 1.
- R10: baud_tick is high for one cycle in every D cycles, where D is the 16-bit divisor. A divisor of 0 behaves as 1, giving a tick in every cycle.
- R11: Offsets 4, 6 and 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (triggers read side effects) |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| word_len | output | 2 | Word-length field of the frame-format register |
| fifo_en | output | 1 | FIFO enable from FIFO control bit 0 |
| baud_tick | output | 1 | 16x oversampling tick |
| tx_data | output | 8 | Byte offered to the serialiser |
| tx_valid | output | 1 | Transmit holding register is full |
| tx_accept | input | 1 | Serialiser takes the offered byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| irq | output | 1 | Received-data interrupt |

## Verification
If the bank-select decode is wrong, the next read of offset 0 or 1 shows it at once, either as divisor bytes in place of data or as data in place of divisor bytes. A stray transmit load shows as tx_valid rising in the cycle after a divisor write. Errors in data ready or overrun show in line status and on irq in the cycle after the strobe or read that caused them. A wrong divisor or a wrong zero rule shows in the spacing between two baud ticks, so it is visible within one divisor period.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FCTL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_FMT  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;

  localparam int FMT_BANK_BIT = 7;

  // Effective tick period: a zero divisor behaves as one.
  function automatic logic [DIV_W-1:0] eff_period(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // Line status packing: bit0 data ready, bit1 overrun, bit5 holding empty.
  function automatic logic [BYTE_W-1:0] pack_status(input logic ready,
                                                     input logic ovr,
                                                     input logic empty);
    logic [BYTE_W-1:0] s;
    s    = '0;
    s[0] = ready;
    s[1] = ovr;
    s[5] = empty;
    return s;
  endfunction
endpackage

// File: rtl/sp_baud_gen.sv
module sp_baud_gen
  import sp_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] divisor,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] period;

  always_comb begin
    period = (divisor == '0) ? W'(1) : divisor;
    tick   = (cnt_q >= period - W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + W'(1);
  end

  // R10: after a tick the next one is at least one cycle away unless the period is 1
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > W'(1) && $stable(divisor)) |=> (!tick || period == W'(1)));
endmodule

// File: rtl/sp_rx_hold.sv
module sp_rx_hold
  import sp_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         consume,
  input  logic         status_read,
  output logic [W-1:0] buf_q,
  output logic         ready_q,
  output logic         ovr_q
);
  logic ovr_event;
  assign ovr_event = in_valid && ready_q && !consume;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (in_valid) begin
        buf_q   <= in_data;
        ready_q <= 1'b1;
      end else if (consume) begin
        ready_q <= 1'b0;
      end
      if (ovr_event)        ovr_q <= 1'b1;
      else if (status_read) ovr_q <= 1'b0;
    end
  end

  // R6: a received byte always leaves data ready set
  a_r6_ready_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ready_q && buf_q == $past(in_data)));
  // R7: an unconsumed byte landing on a full buffer flags overrun
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready_q && !consume) |=> ovr_q);
endmodule

// File: rtl/sp_tx_hold.sv
module sp_tx_hold
  import sp_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         accept,
  output logic [W-1:0] data_q,
  output logic         empty_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (load) begin
      data_q  <= load_data;
      empty_q <= 1'b0;
    end else if (accept && !empty_q) begin
      empty_q <= 1'b1;
    end
  end

  // R8: a load always leaves the holding register full with the written byte
  a_r8_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!empty_q && data_q == $past(load_data)));
  // R8: a handshake without a new load empties the register
  a_r8_accept_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !empty_q && !load) |=> empty_q);
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [1:0]    word_len,
  output logic          fifo_en,
  output logic          baud_tick,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_accept,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          irq
);
  localparam int DVW = 2 * DW;

  logic [DW-1:0] fmt_q, ien_q, fctl_q, div_lo_q, div_hi_q;
  logic          bank;

  // Decoded bus events, named for the checks
  logic wr_fmt, wr_fctl, wr_ien, wr_div_lo, wr_div_hi, wr_hold;
  logic rd_buf, rd_stat;

  logic [DW-1:0] rx_buf;
  logic          rx_ready, rx_ovr, tx_empty;
  logic [DVW-1:0] divisor;

  assign bank = fmt_q[FMT_BANK_BIT];

  always_comb begin
    wr_fmt    = bus_wr && bus_addr == OFS_FMT;
    wr_fctl   = bus_wr && bus_addr == OFS_FCTL;
    wr_ien    = bus_wr && bus_addr == OFS_IEN  && !bank;
    wr_div_hi = bus_wr && bus_addr == OFS_IEN  &&  bank;
    wr_hold   = bus_wr && bus_addr == OFS_DATA && !bank;
    wr_div_lo = bus_wr && bus_addr == OFS_DATA &&  bank;
    rd_buf    = bus_rd && bus_addr == OFS_DATA && !bank;
    rd_stat   = bus_rd && bus_addr == OFS_STAT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q    <= '0;
      ien_q    <= '0;
      fctl_q   <= '0;
      div_lo_q <= DW'(1);
      div_hi_q <= '0;
    end else begin
      if (wr_fmt)    fmt_q    <= bus_wdata;
      if (wr_fctl)   fctl_q   <= bus_wdata;
      if (wr_ien)    ien_q    <= bus_wdata;
      if (wr_div_lo) div_lo_q <= bus_wdata;
      if (wr_div_hi) div_hi_q <= bus_wdata;
    end
  end

  assign divisor = {div_hi_q, div_lo_q};

  sp_rx_hold #(.W(DW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (rx_valid),
    .in_data     (rx_data),
    .consume     (rd_buf),
    .status_read (rd_stat),
    .buf_q       (rx_buf),
    .ready_q     (rx_ready),
    .ovr_q       (rx_ovr)
  );

  sp_tx_hold #(.W(DW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_hold),
    .load_data (bus_wdata),
    .accept    (tx_accept),
    .data_q    (tx_data),
    .empty_q   (tx_empty)
  );

  sp_baud_gen #(.W(DVW)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .tick    (baud_tick)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = bank ? div_lo_q : rx_buf;
      OFS_IEN:  bus_rdata = bank ? div_hi_q : ien_q;
      OFS_FCTL: bus_rdata = fctl_q;
      OFS_FMT:  bus_rdata = fmt_q;
      OFS_STAT: bus_rdata = pack_status(rx_ready, rx_ovr, tx_empty);
      default:  bus_rdata = '0;
    endcase
  end

  assign word_len = fmt_q[1:0];
  assign fifo_en  = fctl_q[0];
  assign tx_valid = !tx_empty;
  assign irq      = ien_q[0] && rx_ready;

  // R9: with the enable held, an arriving byte raises the interrupt next cycle
  a_r9_irq_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ien_q[0] && !wr_ien) |=> irq);
  // R3: divisor-bank writes never disturb the byte offered to the serialiser
  a_r3_bank_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div_lo || wr_div_hi) |=> $stable(tx_data));
  // R9: no interrupt without data ready
  a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !irq);
endmodule

// File: tb/tb_serial_port_regs.sv
module tb_serial_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [1:0] word_len;
  logic       fifo_en, baud_tick, tx_valid, irq;
  logic [7:0] tx_data;
  logic       tx_accept = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_port_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .word_len(word_len), .fifo_en(fifo_en), .baud_tick(baud_tick),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_accept(tx_accept),
    .rx_data(rx_data), .rx_valid(rx_valid), .irq(irq)
  );

  // Bench's own view of the tick period
  function automatic int period_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Look at a register without a read strobe (no side effects)
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    rd(3'd1, v); check("R1 ien", v, 8'h00);
    rd(3'd2, v); check("R1 fctl", v, 8'h00);
    rd(3'd3, v); check("R1 fmt", v, 8'h00);
    rd(3'd5, v); check("R1 status", v, 8'h20);
    wr(3'd3, 8'h80);
    rd(3'd0, v); check("R1 div lo", v, 8'h01);
    rd(3'd1, v); check("R1 div hi", v, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_format;
    logic [7:0] v;
    wr(3'd3, 8'h5B);
    rd(3'd3, v); check("R2 readback", v, 8'h5B);
    check("R2 word_len", word_len, 2'b11);
    wr(3'd2, 8'h01);
    rd(3'd2, v); check("R5 fctl readback", v, 8'h01);
    check("R5 fifo_en", fifo_en, 1);
    wr(3'd2, 8'hC6);
    check("R5 fifo_en off", fifo_en, 0);
    wr(3'd3, 8'h03);
    check("R2 word_len 8bit", word_len, 2'b11);
    rd(3'd4, v); check("R11 ofs4", v, 0);
    rd(3'd6, v); check("R11 ofs6", v, 0);
    rd(3'd7, v); check("R11 ofs7", v, 0);
  endtask

  task automatic t_bank;
    logic [7:0] v;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    check("R3 no tx load", tx_valid, 0);
    wr(3'd1, 8'h12);
    rd(3'd0, v); check("R3 div lo", v, 8'h34);
    rd(3'd1, v); check("R3 div hi", v, 8'h12);
    wr(3'd3, 8'h03);
    rd(3'd1, v); check("R3 ien untouched", v, 8'h00);
    rd(3'd5, v); check("R3 status", v, 8'h20);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R4 ien readback", v, 8'h01);
    push_rx(8'hA7);
    check("R9 irq up", irq, 1);
    rd(3'd5, v); check("R6 ready", v, 8'h21);
    // read while banked must not consume
    wr(3'd3, 8'h83);
    rd(3'd0, v); check("R3 banked read", v, 8'h34);
    wr(3'd3, 8'h03);
    check("R3 ready kept", irq, 1);
    rd(3'd0, v); check("R4 rx byte", v, 8'hA7);
    rd(3'd5, v); check("R6 cleared", v, 8'h20);
    check("R9 irq down", irq, 0);
    wr(3'd1, 8'h00);
    push_rx(8'h11);
    check("R9 irq masked", irq, 0);
    rd(3'd0, v); check("R4 rx byte 2", v, 8'h11);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    push_rx(8'h01);
    push_rx(8'h02);
    peek(3'd5, v); check("R7 overrun set", v, 8'h23);
    rd(3'd5, v);  check("R7 overrun read", v, 8'h23);
    rd(3'd5, v);  check("R7 overrun cleared", v, 8'h21);
    rd(3'd0, v);  check("R7 overwritten", v, 8'h02);
    rd(3'd5, v);  check("R6 empty again", v, 8'h20);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    wr(3'd0, 8'h5A);
    check("R4 tx_valid", tx_valid, 1);
    check("R4 tx_data", tx_data, 8'h5A);
    rd(3'd5, v); check("R8 full", v, 8'h00);
    @(negedge clk); tx_accept = 1'b1;
    @(negedge clk); tx_accept = 1'b0;
    check("R8 accepted", tx_valid, 0);
    rd(3'd5, v); check("R8 empty", v, 8'h20);
  endtask

  task automatic measure(input int d);
    int gap;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'(d));
    wr(3'd1, 8'(d >> 8));
    wr(3'd3, 8'h03);
    gap = 0;
    @(negedge clk);
    while (!baud_tick) @(negedge clk);
    @(negedge clk); gap = 1;
    while (!baud_tick) begin @(negedge clk); gap++; end
    check($sformatf("R10 period div=%0d", d), gap, period_of(d));
  endtask

  task automatic t_baud;
    measure(5);
    measure(0);
    measure(1);
    measure(3);
    measure(592);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format();
    t_bank();
    t_rx();
    t_overrun();
    t_tx();
    t_baud();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule